// File: doc/BRIEF.md
# I2C Transmit Status Flag Register

This block keeps the two transmit-side status flags of an I2C controller inside an 8-bit register that software can read and write. One flag (TX-empty) says the transmit buffer can take another byte. The other (TX-done) says that a byte finished on the wire while no further byte was waiting. The serial engine reports its events to the block as one-cycle strobes. These cover a buffer-to-shifter transfer, entry into transmit mode, a start or repeated start, a slave turning from receiver into transmitter, the ninth SCL rising edge, and the end of a frame in clocked synchronous format.

Software clears a flag with a handshake. It first reads the register while the flag is 1, then writes 0 to that bit. A write of 0 that has no such earlier read does nothing. Any register write disarms the handshake, so an old read cannot permit a later clear. Hardware clears both flags when the transmit buffer is written, or when a DMA service acknowledge arrives. The transmit interrupt request is the TX-empty flag gated by an enable input. The request stays high until the flag clears. The six low register bits are plain storage.

Top module: `i2c_tx_status_reg`

## Requirements
- R1: After reset all 8 bits of rd_data_o are 0 and tx_irq_o is 0.
- R2: TX-empty (bit 7) is 1 in the cycle after any of buf_to_shift_i, tx_mode_set_i, start_issued_i or slave_rx_to_tx_i is high.
- R3: With fmt_sync_i = 0, TX-done (bit 6) is set in the cycle after scl_ninth_rise_i only if bit 7 was 1 when the strobe came; sync_frame_done_i is ignored in this format.
- R4: With fmt_sync_i = 1, TX-done is set in the cycle after sync_frame_done_i; scl_ninth_rise_i is ignored in this format.
- R5: A write (wr_en_i) with 0 in a flag's bit clears that flag if a read (rd_en_i) returned the flag as 1 after the most recent earlier write.
- R6: A write of 0 to a flag bit that has no qualifying read, and any write of 1 to a flag bit, leave that flag unchanged; a read made in the same cycle as a write does not arm.
- R7: txbuf_wr_i or dma_ack_i clears both bit 7 and bit 6 in the next cycle.
- R8: When a set event for a flag and any clear of that flag fall in the same cycle, the flag ends up 1.
- R9: Bits 5:0 take wr_data_i[5:0] on a write and are returned unchanged on rd_data_o.
- R10: tx_irq_o equals rd_data_o[7] AND irq_en_i in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Register contents |
| fmt_sync_i | input | 1 | 1 = clocked synchronous format, 0 = I2C format |
| buf_to_shift_i | input | 1 | Buffer moved into the shift register |
| tx_mode_set_i | input | 1 | Transmit mode bit set |
| start_issued_i | input | 1 | Start or repeated start issued |
| slave_rx_to_tx_i | input | 1 | Slave changed from receive to transmit |
| scl_ninth_rise_i | input | 1 | Ninth SCL rising edge |
| sync_frame_done_i | input | 1 | Last bit of a synchronous frame shifted out |
| txbuf_wr_i | input | 1 | Transmit data buffer written |
| dma_ack_i | input | 1 | DMA serviced the transmit request |
| irq_en_i | input | 1 | Transmit interrupt enable |
| tx_irq_o | output | 1 | Transmit interrupt request |

## Verification
On every cycle the assertions check these rules: the set events of both flags, the TX-empty qualification of the ninth-edge event, the ignored strobe of each format, the hardware clears, that a write of 1 never drops a flag, the low-bit storage, and the interrupt gating. Only the bench's scenarios can show the read-then-write handshake. That covers the clear after a qualifying read, the write of 0 that has no effect, the stale read disarmed by an intervening write, and the set-beats-clear collisions. All of these depend on the order of accesses and not on one cycle's inputs. A behavioural reference model in the bench is compared with the outputs on every clock.

// File: rtl/i2c_txs_pkg.sv
package i2c_txs_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned FLAG_LSB  = REG_W - NUM_FLAGS;  // flags occupy the top bits
  localparam int unsigned TEND_IDX  = 0;                  // bit FLAG_LSB+0 = 6
  localparam int unsigned TDRE_IDX  = 1;                  // bit FLAG_LSB+1 = 7
  localparam int unsigned STORE_W   = FLAG_LSB;

  typedef struct packed {
    logic buf_to_shift;
    logic tx_mode_set;
    logic start_issued;
    logic slave_rx_to_tx;
    logic scl_ninth_rise;
    logic sync_frame_done;
  } tx_evt_t;
endpackage

// File: rtl/i2c_txs_set_decode.sv
module i2c_txs_set_decode
  import i2c_txs_pkg::*;
(
  input  tx_evt_t              evt_i,
  input  logic                 fmt_sync_i,
  input  logic                 tdre_q_i,
  output logic [NUM_FLAGS-1:0] set_o
);
  logic tdre_set, tend_set;

  always_comb begin
    tdre_set = evt_i.buf_to_shift | evt_i.tx_mode_set |
               evt_i.start_issued | evt_i.slave_rx_to_tx;
    // each format listens to its own completion strobe only
    if (fmt_sync_i) tend_set = evt_i.sync_frame_done;
    else            tend_set = evt_i.scl_ninth_rise & tdre_q_i;
    set_o           = '0;
    set_o[TDRE_IDX] = tdre_set;
    set_o[TEND_IDX] = tend_set;
  end
endmodule

// File: rtl/i2c_txs_flag_cell.sv
module i2c_txs_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic hw_clr_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wr_bit_i,
  output logic flag_o
);
  logic flag_q, armed_q;
  logic sw_clr;

  assign sw_clr = wr_i & ~wr_bit_i & armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      // set beats every clear
      if (set_i)                  flag_q <= 1'b1;
      else if (hw_clr_i | sw_clr) flag_q <= 1'b0;
      // any write disarms; a read arms only with a 1 seen
      if (wr_i)      armed_q <= 1'b0;
      else if (rd_i) armed_q <= flag_q;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/i2c_txs_store.sv
module i2c_txs_store #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (wr_i) q <= d_i;
  end

  assign q_o = q;
endmodule

// File: rtl/i2c_tx_status_reg.sv
module i2c_tx_status_reg
  import i2c_txs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             fmt_sync_i,
  input  logic             buf_to_shift_i,
  input  logic             tx_mode_set_i,
  input  logic             start_issued_i,
  input  logic             slave_rx_to_tx_i,
  input  logic             scl_ninth_rise_i,
  input  logic             sync_frame_done_i,
  input  logic             txbuf_wr_i,
  input  logic             dma_ack_i,
  input  logic             irq_en_i,
  output logic             tx_irq_o
);
  tx_evt_t              evt;
  logic [NUM_FLAGS-1:0] flag_set, flags;
  logic [STORE_W-1:0]   store_q;
  logic                 hw_clr;

  assign evt = '{buf_to_shift:    buf_to_shift_i,
                 tx_mode_set:     tx_mode_set_i,
                 start_issued:    start_issued_i,
                 slave_rx_to_tx:  slave_rx_to_tx_i,
                 scl_ninth_rise:  scl_ninth_rise_i,
                 sync_frame_done: sync_frame_done_i};

  assign hw_clr = txbuf_wr_i | dma_ack_i;

  i2c_txs_set_decode u_dec (
    .evt_i      (evt),
    .fmt_sync_i (fmt_sync_i),
    .tdre_q_i   (flags[TDRE_IDX]),
    .set_o      (flag_set)
  );

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    i2c_txs_flag_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (flag_set[i]),
      .hw_clr_i (hw_clr),
      .rd_i     (rd_en_i),
      .wr_i     (wr_en_i),
      .wr_bit_i (wr_data_i[FLAG_LSB+i]),
      .flag_o   (flags[i])
    );
  end

  i2c_txs_store #(.W(STORE_W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_en_i),
    .d_i    (wr_data_i[STORE_W-1:0]),
    .q_o    (store_q)
  );

  assign rd_data_o = {flags, store_q};
  assign tx_irq_o  = flags[TDRE_IDX] & irq_en_i;
endmodule

// File: rtl/i2c_tx_status_reg_chk.sv
module i2c_tx_status_reg_chk
  import i2c_txs_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_en_i,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             fmt_sync_i,
  input logic             buf_to_shift_i,
  input logic             tx_mode_set_i,
  input logic             start_issued_i,
  input logic             slave_rx_to_tx_i,
  input logic             scl_ninth_rise_i,
  input logic             sync_frame_done_i,
  input logic             txbuf_wr_i,
  input logic             dma_ack_i,
  input logic             irq_en_i,
  input logic             tx_irq_o
);
  logic tdre, tend, any_tdre_set, hw_clr;
  assign tdre = rd_data_o[REG_W-1];
  assign tend = rd_data_o[REG_W-2];
  assign any_tdre_set = buf_to_shift_i | tx_mode_set_i | start_issued_i | slave_rx_to_tx_i;
  assign hw_clr = txbuf_wr_i | dma_ack_i;

  a_r2_tdre_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_tdre_set |=> tdre);
  a_r3_ninth_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fmt_sync_i && scl_ninth_rise_i && tdre) |=> tend);
  a_r3_ninth_needs_tdre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fmt_sync_i && scl_ninth_rise_i && !tdre && !tend) |=> !tend);
  a_r3_frame_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fmt_sync_i && sync_frame_done_i && !scl_ninth_rise_i && !tend) |=> !tend);
  a_r4_frame_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_sync_i && sync_frame_done_i) |=> tend);
  a_r4_ninth_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_sync_i && scl_ninth_rise_i && !sync_frame_done_i && !tend) |=> !tend);
  a_r6_write_one_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[REG_W-1] && tdre && !hw_clr) |=> tdre);
  a_r7_hw_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_clr && !any_tdre_set && !scl_ninth_rise_i && !sync_frame_done_i) |=> (!tdre && !tend));
  a_r9_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rd_data_o[REG_W-3:0] == $past(wr_data_i[REG_W-3:0])));
  a_r10_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o == (tdre & irq_en_i));
endmodule

bind i2c_tx_status_reg i2c_tx_status_reg_chk u_chk (.*);

// File: tb/i2c_tx_status_reg_tb.sv
`timescale 1ns/1ps
module i2c_tx_status_reg_tb;
  logic       clk = 0, rst_n = 0;
  logic       rd_en = 0, wr_en = 0, fmt_sync = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       bts = 0, tms = 0, sti = 0, srt = 0, ninth = 0, fdone = 0;
  logic       txw = 0, dma = 0, irq_en = 0, irq;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  i2c_tx_status_reg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .fmt_sync_i(fmt_sync),
    .buf_to_shift_i(bts), .tx_mode_set_i(tms), .start_issued_i(sti),
    .slave_rx_to_tx_i(srt), .scl_ninth_rise_i(ninth), .sync_frame_done_i(fdone),
    .txbuf_wr_i(txw), .dma_ack_i(dma), .irq_en_i(irq_en), .tx_irq_o(irq));

  // behavioural reference model
  int m_e = 0, m_d = 0, arm_e = 0, arm_d = 0, m_low = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_e = 0; m_d = 0; arm_e = 0; arm_d = 0; m_low = 0;
    end else begin
      int ne, nd;
      bit se, sd, ce, cd;
      se = bts | tms | sti | srt;
      sd = fmt_sync ? fdone : (ninth && m_e == 1);
      ce = txw | dma | (wr_en & !wr_data[7] & arm_e == 1);
      cd = txw | dma | (wr_en & !wr_data[6] & arm_d == 1);
      ne = se ? 1 : (ce ? 0 : m_e);
      nd = sd ? 1 : (cd ? 0 : m_d);
      if (wr_en) begin arm_e = 0; arm_d = 0; m_low = wr_data[5:0]; end
      else if (rd_en) begin arm_e = m_e; arm_d = m_d; end
      m_e = ne; m_d = nd;
    end
  end

  function automatic int model_reg();
    return (m_e << 7) | (m_d << 6) | m_low;
  endfunction

  always @(negedge clk) if (!done) begin
    cycles++;
    n_cmp++;
    if (rd_data !== 8'(model_reg()) || irq !== (m_e == 1 && irq_en)) begin
      n_bad++;
      $display("FAIL model R1..R10 cycle %0d: reg=%02h irq=%b expected reg=%02h irq=%b",
               cycles, rd_data, irq, 8'(model_reg()), (m_e == 1 && irq_en));
    end
  end

  task automatic check(string tag, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // drive after posedge+2, strobes last one cycle
  task automatic tick();
    @(posedge clk); #2;
    rd_en = 0; wr_en = 0; bts = 0; tms = 0; sti = 0; srt = 0;
    ninth = 0; fdone = 0; txw = 0; dma = 0;
  endtask

  task automatic rd(); rd_en = 1; tick(); endtask
  task automatic wr(logic [7:0] d); wr_en = 1; wr_data = d; tick(); endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    check("R1 reset reg", rd_data, 0);
    check("R1 reset irq", irq, 0);

    bts = 1; tick();
    check("R2 buf_to_shift sets tdre", rd_data[7], 1);
    irq_en = 1; #1;
    check("R10 irq on", irq, 1);
    irq_en = 0; #1;
    check("R10 irq gated", irq, 0);

    wr(8'h00);
    check("R6 unarmed write0 keeps", rd_data[7], 1);
    rd(); wr(8'h00);
    check("R5 read then write0 clears", rd_data[7], 0);

    sti = 1; tick();
    check("R2 start sets tdre", rd_data[7], 1);
    rd(); wr(8'h80);
    check("R6 write1 keeps", rd_data[7], 1);
    wr(8'h00);
    check("R6 stale read no clear", rd_data[7], 1);
    rd_en = 1; wr_en = 1; wr_data = 8'h00; tick();
    check("R6 read with write does not arm", rd_data[7], 1);
    wr(8'h00);
    check("R6 same-cycle read not armed", rd_data[7], 1);

    txw = 1; tick();
    check("R7 txbuf write clears tdre", rd_data[7], 0);
    tms = 1; tick();
    check("R2 tx_mode sets tdre", rd_data[7], 1);
    dma = 1; tick();
    check("R7 dma ack clears tdre", rd_data[7], 0);

    ninth = 1; tick();
    check("R3 ninth without tdre", rd_data[6], 0);
    srt = 1; tick();
    check("R2 slave rx->tx sets tdre", rd_data[7], 1);
    fdone = 1; tick();
    check("R3 frame_done ignored in i2c", rd_data[6], 0);
    ninth = 1; tick();
    check("R3 ninth with tdre sets tend", rd_data[6], 1);
    txw = 1; tick();
    check("R7 txbuf clears both", rd_data[7:6], 0);

    fmt_sync = 1; bts = 1; tick();
    ninth = 1; tick();
    check("R4 ninth ignored in sync", rd_data[6], 0);
    fdone = 1; tick();
    check("R4 frame_done sets tend", rd_data[6], 1);
    rd(); wr(8'h80);
    check("R5 write0 clears tend only", rd_data[7:6], 2);
    fmt_sync = 0;

    rd(); wr_en = 1; wr_data = 8'h00; bts = 1; tick();
    check("R8 set beats sw clear", rd_data[7], 1);
    txw = 1; sti = 1; tick();
    check("R8 set beats hw clear", rd_data[7], 1);

    wr(8'hAA);
    check("R9 low bits stored", rd_data[5:0], 6'h2A);
    check("R6 write1 keeps tdre", rd_data[7], 1);
    wr(8'hD5);
    check("R9 low bits rewritten", rd_data[5:0], 6'h15);

    tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule